// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the processor-facing side of a three-channel interval timer. A host reaches it through a 2-bit address, an 8-bit write bus, an 8-bit read bus and separate read and write strobes. Address 3 takes control words. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. The counting engines sit outside this block. Each engine supplies its live 16-bit count and its output level, and receives a load strobe with a 16-bit reload value plus its programmed mode and BCD flag.

Every channel keeps its own access mode: low byte only, high byte only, or low byte then high byte. Separate read and write byte sequencers follow that mode, so 16-bit values move over the 8-bit bus in the programmed order. The host can freeze the count of one channel with a latch control word. A read-back command can freeze the count and/or a status byte on several channels in one write. Data reads return a pending status byte first, then a pending frozen count, and otherwise the live count.

Read data is registered. The byte chosen at the read strobe appears on `rdata` one cycle later and stays there until the next read.

Top module: `tmr_host_if`

## Requirements
- R1: Address 3 is the control port and addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. A read strobe updates `rdata` at the next clock edge, and `rdata` holds its value while no read strobe is present. A read of address 3 returns 0x00.
- R2: After reset, every channel is in low-then-high access mode with mode 0 and BCD flag 0. Both of its byte sequencers point at the low byte, no count or status latch is pending, `rdata` is 0x00 and no load strobe is active.
- R3: A control word whose bits 7:6 name a channel (0 to 2) and whose bits 5:4 are non-zero does three things: it sets that channel's access mode from bits 5:4 (1 = low byte only, 2 = high byte only, 3 = low then high), it sets the mode from bits 3:1 and the BCD flag from bit 0, and it returns both byte sequencers of that channel to the low byte. A control write never produces a load strobe.
- R4: A control word with bits 5:4 equal to 0 latches the current live count of the channel named in bits 7:6. It leaves that channel's mode, BCD flag and access mode unchanged.
- R5: Data writes load the channel as follows. In low-only mode the value loaded is {0x00, byte}. In high-only mode it is {byte, 0x00}. In low-then-high mode the first byte is held and the second completes the value {second, first}. A completed load raises that channel's `load_stb` bit for exactly one cycle, starting the cycle after the write strobe, with the value on its `load_val` field. At most one bit is ever set.
- R6: A control word with bits 7:6 equal to 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. For each selected channel, bit 5 low latches the count and bit 4 low latches the status.
- R7: The status byte is captured when it is latched: bit 7 is the channel output level, bit 6 is 0, bits 5:4 are the access mode, bits 3:1 are the mode and bit 0 is the BCD flag.
- R8: A count latch request is ignored while that channel holds an unread latched count. A status latch request is ignored while that channel holds an unread status.
- R9: A data read returns the pending status byte if there is one. Otherwise it returns the pending latched count, and otherwise the live count. Reading the status releases the status only.
- R10: A latched count taken in low-then-high mode is read as the low byte and then the high byte, and is then released. One taken in low-only mode returns the low byte, and one taken in high-only mode returns the high byte, each released after a single read.
- R11: Live reads return the low byte in low-only mode and the high byte in high-only mode. In low-then-high mode they alternate low, high, low, starting from the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address: 0 to 2 are channel data ports, 3 is the control port |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| live_cnt | input | 48 | Live counts of the channels, channel i in bits 16i+15:16i |
| ch_out | input | 3 | Output level of each channel |
| load_stb | output | 3 | One-cycle reload strobe per channel |
| load_val | output | 48 | Reload value per channel, channel i in bits 16i+15:16i |
| ch_mode | output | 9 | Programmed mode per channel, channel i in bits 3i+2:3i |
| ch_bcd | output | 3 | Programmed BCD flag per channel |

## Verification
The assertions assume that a write and a read never occur in the same cycle, and that the address and strobes are known in every cycle after reset. Only under these conditions do the pulse-after-data-write and the held-read-data properties describe the host protocol. The bench therefore issues one strobe at a time, each lasting one cycle. It changes the bus only on the falling clock edge and keeps both strobes low during reset. Live counts and output levels change only between accesses, so each latch captures a value that the bench knows.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;
  // Access modes; ACC_NONE doubles as "no latched count pending".
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;

  typedef struct packed {
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } chan_cfg_t;

  localparam logic [1:0] CTRL_ADDR = 2'd3;
endpackage

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8
) (
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_CH-1:0] cfg_we,
  output logic [NUM_CH-1:0] cnt_lat_req,
  output logic [NUM_CH-1:0] sts_lat_req,
  output logic [NUM_CH-1:0] data_we
);
  import tmr_host_pkg::*;

  logic ctrl_wr;
  logic is_rdbk;
  logic is_latch;

  assign ctrl_wr  = wr_en && (addr == CTRL_ADDR);
  assign is_rdbk  = (wdata[7:6] == 2'd3);
  assign is_latch = (wdata[5:4] == 2'd0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    logic named;
    logic picked;
    assign named  = (wdata[7:6] == 2'(i));
    assign picked = wdata[1+i];
    assign cfg_we[i]      = ctrl_wr && !is_rdbk && named && !is_latch;
    assign cnt_lat_req[i] = ctrl_wr && ((!is_rdbk && named && is_latch) ||
                                        (is_rdbk && picked && !wdata[5]));
    assign sts_lat_req[i] = ctrl_wr && is_rdbk && picked && !wdata[4];
    assign data_we[i]     = wr_en && (addr == 2'(i));
  end

  // bits 3:1 and 0 are consumed by the channel registers
  logic unused_ok;
  assign unused_ok = ^{wdata[DATA_W-1:0]} & 1'b0;
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cnt_lat_req,
  input  logic              sts_lat_req,
  input  logic              data_we,
  input  logic              data_re,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              out_lvl,
  output logic [DATA_W-1:0] rd_byte,
  output logic              load_stb,
  output logic [CNT_W-1:0]  load_val,
  output logic [2:0]        mode,
  output logic              bcd
);
  import tmr_host_pkg::*;

  chan_cfg_t         cfg;
  logic              wr_hi, rd_hi;
  logic [DATA_W-1:0] wr_hold;
  acc_e              lat_kind;
  logic [CNT_W-1:0]  lat_val;
  logic              sts_pend;
  logic [DATA_W-1:0] sts_val;

  assign mode = cfg.mode;
  assign bcd  = cfg.bcd;

  // byte returned by a read in the current cycle: status, latch, live
  always_comb begin
    if (sts_pend) begin
      rd_byte = sts_val;
    end else if (lat_kind != ACC_NONE) begin
      case (lat_kind)
        ACC_HI:  rd_byte = lat_val[CNT_W-1:DATA_W];
        default: rd_byte = lat_val[DATA_W-1:0];
      endcase
    end else begin
      case (cfg.acc)
        ACC_HI:   rd_byte = live_cnt[CNT_W-1:DATA_W];
        ACC_WORD: rd_byte = rd_hi ? live_cnt[CNT_W-1:DATA_W] : live_cnt[DATA_W-1:0];
        default:  rd_byte = live_cnt[DATA_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '{acc: ACC_WORD, mode: 3'd0, bcd: 1'b0};
      wr_hi    <= 1'b0;
      rd_hi    <= 1'b0;
      wr_hold  <= '0;
      lat_kind <= ACC_NONE;
      lat_val  <= '0;
      sts_pend <= 1'b0;
      sts_val  <= '0;
      load_stb <= 1'b0;
      load_val <= '0;
    end else begin
      load_stb <= 1'b0;
      if (data_re) begin
        if (sts_pend) begin
          sts_pend <= 1'b0;
        end else if (lat_kind != ACC_NONE) begin
          lat_kind <= (lat_kind == ACC_WORD) ? ACC_HI : ACC_NONE;
        end else if (cfg.acc == ACC_WORD) begin
          rd_hi <= !rd_hi;
        end
      end
      if (data_we) begin
        case (cfg.acc)
          ACC_LO: begin
            load_stb <= 1'b1;
            load_val <= {{DATA_W{1'b0}}, wdata};
          end
          ACC_HI: begin
            load_stb <= 1'b1;
            load_val <= {wdata, {DATA_W{1'b0}}};
          end
          ACC_WORD: begin
            if (wr_hi) begin
              load_stb <= 1'b1;
              load_val <= {wdata, wr_hold};
              wr_hi    <= 1'b0;
            end else begin
              wr_hold <= wdata;
              wr_hi   <= 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (cnt_lat_req && (lat_kind == ACC_NONE)) begin
        lat_val  <= live_cnt;
        lat_kind <= cfg.acc;
      end
      if (sts_lat_req && !sts_pend) begin
        sts_val  <= {out_lvl, 1'b0, cfg.acc, cfg.mode, cfg.bcd};
        sts_pend <= 1'b1;
      end
      if (cfg_we) begin
        cfg   <= '{acc: acc_e'(wdata[5:4]), mode: wdata[3:1], bcd: wdata[0]};
        wr_hi <= 1'b0;
        rd_hi <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              addr,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  input  logic [NUM_CH*CNT_W-1:0] live_cnt,
  input  logic [NUM_CH-1:0]       ch_out,
  output logic [NUM_CH-1:0]       load_stb,
  output logic [NUM_CH*CNT_W-1:0] load_val,
  output logic [NUM_CH*3-1:0]     ch_mode,
  output logic [NUM_CH-1:0]       ch_bcd
);
  logic [NUM_CH-1:0] cfg_we, cnt_lat_req, sts_lat_req, data_we;
  logic [DATA_W-1:0] rd_byte [NUM_CH];
  logic [DATA_W-1:0] rd_sel;

  tmr_ctrl_decode #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dec (
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .cfg_we      (cfg_we),
    .cnt_lat_req (cnt_lat_req),
    .sts_lat_req (sts_lat_req),
    .data_we     (data_we)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tmr_chan_port #(.DATA_W(DATA_W)) u_ch (
      .clk         (clk),
      .rst         (rst),
      .cfg_we      (cfg_we[i]),
      .cnt_lat_req (cnt_lat_req[i]),
      .sts_lat_req (sts_lat_req[i]),
      .data_we     (data_we[i]),
      .data_re     (rd_en && (addr == 2'(i))),
      .wdata       (wdata),
      .live_cnt    (live_cnt[i*CNT_W +: CNT_W]),
      .out_lvl     (ch_out[i]),
      .rd_byte     (rd_byte[i]),
      .load_stb    (load_stb[i]),
      .load_val    (load_val[i*CNT_W +: CNT_W]),
      .mode        (ch_mode[i*3 +: 3]),
      .bcd         (ch_bcd[i])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == 2'(i)) rd_sel = rd_byte[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_sel;
    end
  end
endmodule

// File: rtl/tmr_host_if_chk.sv
module tmr_host_if_chk #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rdata,
  input logic [NUM_CH-1:0] load_stb
);
  assert_load_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(load_stb));

  assert_load_follows_data_R5: assert property (@(posedge clk) disable iff (rst)
    (|load_stb) |-> $past(wr_en && (addr != 2'd3)));

  assert_ctrl_no_load_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == 2'd3)) |=> (load_stb == '0));

  assert_ctrl_read_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == 2'd3)) |=> (rdata == '0));

  assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  assert_reset_idle_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((load_stb == '0) && (rdata == '0)));
endmodule

bind tmr_host_if tmr_host_if_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .addr     (addr),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rdata    (rdata),
  .load_stb (load_stb)
);

// File: tb/tmr_host_if_test.sv
module tmr_host_if_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] live_cnt = '0;
  logic [2:0]  ch_out = '0;
  logic [2:0]  load_stb;
  logic [47:0] load_val;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd;

  int total = 0;
  int bad = 0;
  logic [2:0]  seen_stb;
  logic [47:0] seen_val;
  logic [7:0]  rb;

  always #10 clk = !clk;

  tmr_host_if uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .ch_out(ch_out),
    .load_stb(load_stb), .load_val(load_val), .ch_mode(ch_mode), .ch_bcd(ch_bcd)
  );

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    seen_stb = load_stb;
    seen_val = load_val;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic set_live(input int ch, input logic [15:0] v);
    live_cnt[ch*16 +: 16] = v;
  endtask

  task automatic t_reset;
    check("R2 rdata after reset", 48'(rdata), 48'h00);
    check("R2 no load after reset", 48'(load_stb), 48'h0);
    check("R2 modes after reset", 48'({ch_mode, ch_bcd}), 48'h0);
    ch_out = 3'b111;
    wr(2'd3, 8'hE2);
    rd(2'd0, rb);
    check("R2 R7 reset status ch0", 48'(rb), 48'hB0);
  endtask

  task automatic t_live_word;
    set_live(0, 16'hBEEF);
    rd(2'd0, rb); check("R11 word live first low", 48'(rb), 48'hEF);
    rd(2'd0, rb); check("R11 word live then high", 48'(rb), 48'hBE);
    rd(2'd0, rb); check("R11 word live back low", 48'(rb), 48'hEF);
  endtask

  task automatic t_write_word;
    wr(2'd1, 8'h34);
    check("R5 first byte holds", 48'(seen_stb), 48'h0);
    wr(2'd1, 8'h12);
    check("R5 word load strobe", 48'(seen_stb), 48'h2);
    check("R5 word load value", 48'(seen_val[31:16]), 48'h1234);
    @(negedge clk);
    check("R5 strobe one cycle", 48'(load_stb), 48'h0);
  endtask

  task automatic t_lo_only;
    wr(2'd3, 8'h54);
    check("R3 ctrl no load", 48'(seen_stb), 48'h0);
    check("R3 ch1 mode", 48'(ch_mode[5:3]), 48'h2);
    wr(2'd1, 8'hAB);
    check("R5 low-only strobe", 48'(seen_stb), 48'h2);
    check("R5 low-only value", 48'(seen_val[31:16]), 48'h00AB);
    set_live(1, 16'h1357);
    rd(2'd1, rb); check("R11 low-only live", 48'(rb), 48'h57);
    rd(2'd1, rb); check("R11 low-only live again", 48'(rb), 48'h57);
  endtask

  task automatic t_hi_only;
    wr(2'd3, 8'hA7);
    check("R3 ch2 mode", 48'(ch_mode[8:6]), 48'h3);
    check("R3 ch2 bcd", 48'(ch_bcd[2]), 48'h1);
    wr(2'd2, 8'h5C);
    check("R5 high-only strobe", 48'(seen_stb), 48'h4);
    check("R5 high-only value", 48'(seen_val[47:32]), 48'h5C00);
    set_live(2, 16'h2468);
    rd(2'd2, rb); check("R11 high-only live", 48'(rb), 48'h24);
    rd(2'd2, rb); check("R11 high-only live again", 48'(rb), 48'h24);
  endtask

  task automatic t_seq_reset;
    wr(2'd0, 8'h77);
    check("R5 ch0 held byte", 48'(seen_stb), 48'h0);
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h11);
    check("R3 write sequencer restarted", 48'(seen_stb), 48'h0);
    wr(2'd0, 8'h22);
    check("R3 R5 ch0 value after restart", 48'(seen_val[15:0]), 48'h2211);
    rd(2'd0, rb);
    check("R3 read sequencer restarted", 48'(rb), 48'hEF);
  endtask

  task automatic t_count_latch;
    wr(2'd3, 8'h30);
    set_live(0, 16'h4321);
    wr(2'd3, 8'h00);
    set_live(0, 16'h9999);
    wr(2'd3, 8'h00);
    check("R4 latch keeps mode", 48'({ch_mode[2:0], ch_bcd[0]}), 48'h0);
    rd(2'd0, rb); check("R10 latched low", 48'(rb), 48'h21);
    rd(2'd0, rb); check("R8 R10 latched high", 48'(rb), 48'h43);
    rd(2'd0, rb); check("R10 released to live", 48'(rb), 48'h99);
    rd(2'd0, rb); check("R4 access kept word", 48'(rb), 48'h99);
  endtask

  task automatic t_readback;
    wr(2'd3, 8'h30);
    ch_out = 3'b101;
    set_live(0, 16'hA1B2); set_live(1, 16'h00C3); set_live(2, 16'hD4E5);
    wr(2'd3, 8'hCE);
    ch_out = 3'b010;
    set_live(0, 16'h5566); set_live(1, 16'h7788); set_live(2, 16'h99AA);
    wr(2'd3, 8'hE2);
    rd(2'd0, rb); check("R7 R8 R9 ch0 status first", 48'(rb), 48'hB0);
    rd(2'd0, rb); check("R6 R10 ch0 latched low", 48'(rb), 48'hB2);
    rd(2'd0, rb); check("R6 R10 ch0 latched high", 48'(rb), 48'hA1);
    rd(2'd0, rb); check("R9 ch0 live after latches", 48'(rb), 48'h66);
    rd(2'd1, rb); check("R7 ch1 status", 48'(rb), 48'h14);
    rd(2'd1, rb); check("R10 ch1 low-only latch", 48'(rb), 48'hC3);
    rd(2'd1, rb); check("R10 ch1 released", 48'(rb), 48'h88);
    rd(2'd2, rb); check("R7 ch2 status", 48'(rb), 48'hA7);
    rd(2'd2, rb); check("R10 ch2 high-only latch", 48'(rb), 48'hD4);
    rd(2'd2, rb); check("R10 ch2 released", 48'(rb), 48'h99);
    wr(2'd3, 8'hDA);
    rd(2'd0, rb); check("R6 count-only readback low", 48'(rb), 48'h66);
    rd(2'd1, rb); check("R6 unselected ch1 live", 48'(rb), 48'h88);
    rd(2'd2, rb); check("R6 ch2 count-only latch", 48'(rb), 48'h99);
  endtask

  task automatic t_ctrl_read;
    rd(2'd3, rb);
    check("R1 control port reads zero", 48'(rb), 48'h00);
    @(negedge clk);
    check("R1 rdata held", 48'(rdata), 48'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_live_word();
    t_write_word();
    t_lo_only();
    t_hi_only();
    t_seq_reset();
    t_count_latch();
    t_readback();
    t_ctrl_read();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule